// File: doc/BRIEF.md
# Bus Byte Parity Generator and Checker

This block sits on the edge of a wide internal bus port. It has a 36-bit address, a 128-bit data path and one write enable per data byte. Requests leaving toward the bus get byte parity attached to them. Requests and completions arriving from the bus have their parity compared against a locally computed value. A two-bit transaction type picks the work for each beat:

- generate address parity only;
- generate both address and data parity;
- check data parity only;
- check both address and data parity.

Each data parity bit also folds in the write enable of its byte lane. The highest address parity bit protects only the four address bits above bit 31.

Upstream logic can flag individual byte lanes as known bad. The block then poisons those lanes: it inverts their generated parity bits, so the receiver sees a parity error exactly where the bad data is. Checking produces per-group error vectors, registered one cycle after the beat. It also produces a sticky summary flag that a write-one-to-clear strobe resets.

Top module: `byte_parity_unit`

## Requirements
- R1: Address parity bit g (g = 0..3) is the XOR of address bits 8g+7 down to 8g, and bit 4 is the XOR of address bits 35..32 only.
- R2: Data parity bit k (k = 0..15) is the XOR of data bits 8k+7..8k and byteEn[k].
- R3: For txnType 2'b10, one cycle after a valid beat, addrParOut and dataParOut carry the generated parity and both error vectors are zero, whatever the parity inputs hold.
- R4: For txnType 2'b11, one cycle after a valid beat, addrParOut carries the generated address parity, dataParOut is zero and both error vectors are zero.
- R5: For txnType 2'b00, one cycle after a valid beat, addrErr[g] is set exactly when addrParIn[g] differs from the R1 value, and dataErr[k] is set exactly when dataParIn[k] differs from the R2 value. Both parity outputs are zero.
- R6: For txnType 2'b01, one cycle after a valid beat, only dataErr is computed as in R5. addrErr, addrParOut and dataParOut are zero, whatever addrParIn holds.
- R7: With txnType 2'b10, dataParOut[k] is inverted when laneBad[k] is set. For every other type laneBad has no effect on any output, and it never affects addrParOut.
- R8: One cycle after a cycle with beatValid low, all parity outputs and error vectors are zero.
- R9: errSticky rises in the same cycle as any set bit of addrErr or dataErr. It then stays set until errClr is high in a cycle that brings no new error. A new error arriving with errClr keeps the flag set.
- R10: While rstN is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| beatValid | input | 1 | A beat is present this cycle |
| txnType | input | 2 | 00 check addr+data, 01 check data, 10 generate addr+data, 11 generate addr |
| addrIn | input | 36 | Address of the beat |
| addrParIn | input | 5 | Received address parity |
| dataIn | input | 128 | Data of the beat |
| byteEn | input | 16 | Byte-write enables, one per lane |
| dataParIn | input | 16 | Received data parity |
| laneBad | input | 16 | Per-lane known-bad marker for poisoning |
| errClr | input | 1 | Write-one-to-clear for errSticky |
| addrParOut | output | 5 | Generated address parity (registered) |
| dataParOut | output | 16 | Generated, possibly poisoned, data parity (registered) |
| addrErr | output | 5 | Address parity mismatch per group (registered) |
| dataErr | output | 16 | Data parity mismatch per lane (registered) |
| errSticky | output | 1 | Sticky flag for any parity error |

## Verification
The bound checker enforces the per-type masking on every cycle:
- generation types never raise errors;
- the data-only check type never reports address errors and never drives parity;
- the address-only generation type never drives data parity;
- idle cycles clear everything;
- the sticky flag covers every error, holds without a clear, and rises only with an error.

The parity values themselves can only be shown by the bench's scenarios. The same goes for the per-lane poisoning of exact lanes and the clear-versus-new-error race. To cover them, the bench sweeps single address bits, single data bits and single enables through every type, then runs random beats with random corruption masks.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    TXN_CHK_AD  = 2'b00,
    TXN_CHK_D   = 2'b01,
    TXN_GEN_AD  = 2'b10,
    TXN_GEN_A   = 2'b11
  } txnType_e;

  typedef struct packed {
    logic chkAddr;
    logic chkData;
    logic genAddr;
    logic genData;
  } parStrobe_t;
endpackage

// File: rtl/bpu_ctrl.sv
module bpu_ctrl
  import bpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       beatValid,
  input  logic [1:0] txnType,
  input  logic       errClr,
  input  logic       anyErrNxt,
  output parStrobe_t strobe,
  output logic       errSticky
);
  always_comb begin
    strobe = '0;
    if (beatValid) begin
      unique case (txnType_e'(txnType))
        TXN_CHK_AD: begin strobe.chkAddr = 1'b1; strobe.chkData = 1'b1; end
        TXN_CHK_D:  strobe.chkData = 1'b1;
        TXN_GEN_AD: begin strobe.genAddr = 1'b1; strobe.genData = 1'b1; end
        TXN_GEN_A:  strobe.genAddr = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

  // a new error outranks a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errSticky <= 1'b0;
    else       errSticky <= (errSticky & ~errClr) | anyErrNxt;
  end
endmodule

// File: rtl/bpu_datapath.sv
module bpu_datapath
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  localparam int NUM_AGRP  = (ADDR_W + LANE_W - 1) / LANE_W,
  localparam int NUM_LANES = DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  parStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [NUM_AGRP-1:0]  addrParIn,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic [NUM_LANES-1:0] byteEn,
  input  logic [NUM_LANES-1:0] dataParIn,
  input  logic [NUM_LANES-1:0] laneBad,
  output logic                 anyErrNxt,
  output logic [NUM_AGRP-1:0]  addrParOut,
  output logic [NUM_LANES-1:0] dataParOut,
  output logic [NUM_AGRP-1:0]  addrErr,
  output logic [NUM_LANES-1:0] dataErr
);
  logic [NUM_AGRP-1:0]  addrParCalc;
  logic [NUM_LANES-1:0] dataParCalc;

  // last address group may be narrower than a lane
  for (genvar g = 0; g < NUM_AGRP; g++) begin : gAddrGrp
    localparam int LO = g * LANE_W;
    localparam int HI = (LO + LANE_W > ADDR_W) ? ADDR_W - 1 : LO + LANE_W - 1;
    assign addrParCalc[g] = ^addrIn[HI:LO];
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : gDataLane
    assign dataParCalc[k] = (^dataIn[k*LANE_W +: LANE_W]) ^ byteEn[k];
  end

  logic [NUM_AGRP-1:0]  addrErrNxt, addrParNxt;
  logic [NUM_LANES-1:0] dataErrNxt, dataParNxt;

  always_comb begin
    addrErrNxt = strobe.chkAddr ? (addrParCalc ^ addrParIn) : '0;
    dataErrNxt = strobe.chkData ? (dataParCalc ^ dataParIn) : '0;
    addrParNxt = strobe.genAddr ? addrParCalc : '0;
    dataParNxt = strobe.genData ? (dataParCalc ^ laneBad) : '0;
    anyErrNxt  = (|addrErrNxt) | (|dataErrNxt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrParOut <= '0;
      dataParOut <= '0;
      addrErr    <= '0;
      dataErr    <= '0;
    end else begin
      addrParOut <= addrParNxt;
      dataParOut <= dataParNxt;
      addrErr    <= addrErrNxt;
      dataErr    <= dataErrNxt;
    end
  end
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  localparam int NUM_AGRP  = (ADDR_W + LANE_W - 1) / LANE_W,
  localparam int NUM_LANES = DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 beatValid,
  input  logic [1:0]           txnType,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [NUM_AGRP-1:0]  addrParIn,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic [NUM_LANES-1:0] byteEn,
  input  logic [NUM_LANES-1:0] dataParIn,
  input  logic [NUM_LANES-1:0] laneBad,
  input  logic                 errClr,
  output logic [NUM_AGRP-1:0]  addrParOut,
  output logic [NUM_LANES-1:0] dataParOut,
  output logic [NUM_AGRP-1:0]  addrErr,
  output logic [NUM_LANES-1:0] dataErr,
  output logic                 errSticky
);
  parStrobe_t strobe;
  logic       anyErrNxt;

  bpu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .txnType(txnType),
    .errClr(errClr), .anyErrNxt(anyErrNxt), .strobe(strobe), .errSticky(errSticky)
  );

  bpu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn), .addrParIn(addrParIn),
    .dataIn(dataIn), .byteEn(byteEn), .dataParIn(dataParIn), .laneBad(laneBad),
    .anyErrNxt(anyErrNxt), .addrParOut(addrParOut), .dataParOut(dataParOut),
    .addrErr(addrErr), .dataErr(dataErr)
  );
endmodule

// File: rtl/byte_parity_unit_chk.sv
module byte_parity_unit_chk
  import bpu_pkg::*;
#(
  parameter int NUM_AGRP  = 5,
  parameter int NUM_LANES = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 beatValid,
  input logic [1:0]           txnType,
  input logic                 errClr,
  input logic [NUM_AGRP-1:0]  addrParOut,
  input logic [NUM_LANES-1:0] dataParOut,
  input logic [NUM_AGRP-1:0]  addrErr,
  input logic [NUM_LANES-1:0] dataErr,
  input logic                 errSticky
);
  // R3
  gen_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && txnType[1]) |=> (addrErr == '0 && dataErr == '0));

  // R4
  rdreq_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && txnType == TXN_GEN_A) |=> (dataParOut == '0));

  // R5
  check_no_gen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !txnType[1]) |=> (addrParOut == '0 && dataParOut == '0));

  // R6
  cpl_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && txnType == TXN_CHK_D) |=> (addrErr == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !beatValid |=> (addrParOut == '0 && dataParOut == '0 && addrErr == '0 && dataErr == '0));

  // R9
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|addrErr) || (|dataErr)) |-> errSticky);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !errClr) |=> errSticky);

  // R9
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSticky) |-> ((|addrErr) || (|dataErr)));
endmodule

bind byte_parity_unit byte_parity_unit_chk #(.NUM_AGRP(NUM_AGRP), .NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rstN(rstN), .beatValid(beatValid), .txnType(txnType), .errClr(errClr),
  .addrParOut(addrParOut), .dataParOut(dataParOut), .addrErr(addrErr),
  .dataErr(dataErr), .errSticky(errSticky)
);

// File: tb/test_byte_parity_unit.sv
module test_byte_parity_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         beatValid;
  logic [1:0]   txnType;
  logic [35:0]  addrIn;
  logic [4:0]   addrParIn;
  logic [127:0] dataIn;
  logic [15:0]  byteEn, dataParIn, laneBad;
  logic         errClr;
  logic [4:0]   addrParOut, addrErr;
  logic [15:0]  dataParOut, dataErr;
  logic         errSticky;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;
  logic expSticky = 1'b0;

  always #4 clk = ~clk;

  byte_parity_unit i_byte_parity_unit (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .txnType(txnType),
    .addrIn(addrIn), .addrParIn(addrParIn), .dataIn(dataIn), .byteEn(byteEn),
    .dataParIn(dataParIn), .laneBad(laneBad), .errClr(errClr),
    .addrParOut(addrParOut), .dataParOut(dataParOut), .addrErr(addrErr),
    .dataErr(dataErr), .errSticky(errSticky)
  );

  // R1: count ones per group, parity = count mod 2
  function automatic logic [4:0] expAddrPar(input logic [35:0] a);
    int cnt [5];
    logic [4:0] p;
    for (int g = 0; g < 5; g++) cnt[g] = 0;
    for (int b = 0; b < 36; b++) if (a[b]) cnt[b / 8]++;
    for (int g = 0; g < 5; g++) p[g] = logic'(cnt[g] % 2);
    return p;
  endfunction

  // R2
  function automatic logic [15:0] expDataPar(input logic [127:0] d, input logic [15:0] be);
    int cnt [16];
    logic [15:0] p;
    for (int k = 0; k < 16; k++) cnt[k] = be[k] ? 1 : 0;
    for (int b = 0; b < 128; b++) if (d[b]) cnt[b / 8]++;
    for (int k = 0; k < 16; k++) p[k] = logic'(cnt[k] % 2);
    return p;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic [1:0] t, input logic [35:0] a,
                      input logic [127:0] d, input logic [15:0] be, input logic [15:0] bad,
                      input logic clr, input logic [4:0] aMask, input logic [15:0] dMask);
    logic [4:0]  ePar, eAOut, eAErr;
    logic [15:0] dPar, eDOut, eDErr;
    ePar = expAddrPar(a);
    dPar = expDataPar(d, be);
    eAOut = '0; eDOut = '0; eAErr = '0; eDErr = '0;
    if (v) begin
      case (t)
        2'b00: begin eAErr = aMask; eDErr = dMask; end
        2'b01: eDErr = dMask;
        2'b10: begin eAOut = ePar; eDOut = dPar ^ bad; end
        default: eAOut = ePar;
      endcase
    end
    expSticky = (expSticky & ~clr) | (|eAErr) | (|eDErr);
    @(negedge clk);
    beatValid = v; txnType = t; addrIn = a; dataIn = d; byteEn = be;
    laneBad = bad; errClr = clr;
    addrParIn = ePar ^ aMask;
    dataParIn = dPar ^ dMask;
    @(posedge clk); #1;
    check(v ? (t[1] ? "R1 R2 R3 R4 R7" : "R1 R2 R5 R6") : "R8", 128'(addrParOut), 128'(eAOut));
    check(v ? (t[1] ? "R2 R3 R4 R7" : "R2 R5 R6 R7") : "R8", 128'(dataParOut), 128'(eDOut));
    check(v ? "R1 R3 R5 R6" : "R8", 128'(addrErr), 128'(eAErr));
    check(v ? "R2 R3 R4 R5 R6" : "R8", 128'(dataErr), 128'(eDErr));
    check("R9", 128'(errSticky), 128'(expSticky));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rstN = 1'b0; beatValid = 0; txnType = 0; addrIn = 0; addrParIn = 0; dataIn = 0;
    byteEn = 0; dataParIn = 0; laneBad = 0; errClr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", 128'({addrParOut, dataParOut, addrErr, dataErr, errSticky}), 128'(0));
    @(negedge clk) rstN = 1'b1;

    for (int t = 0; t < 4; t++) begin
      // the received-parity masks are for check types only (gen types ignore received parity)
      for (int i = 0; i < 36; i++)
        beat(1, 2'(t), 36'(1) << i, '0, '0, 16'($urandom),
             0, t[1] ? 5'(0) : 5'(1 << (i % 5)), t[1] ? 16'(0) : 16'($urandom));
      for (int i = 0; i < 128; i++)
        beat(1, 2'(t), 36'($urandom), 128'(1) << i, 16'($urandom), 16'($urandom),
             1, '0, t[1] ? 16'(0) : 16'(1 << (i % 16)));
      for (int k = 0; k < 16; k++)
        beat(1, 2'(t), '0, '0, 16'(1) << k, 16'(1) << k, 0, '0, '0);
      for (int n = 0; n < 150; n++)
        beat(1, 2'(t), {4'($urandom), 32'($urandom)}, rnd128(), 16'($urandom), 16'($urandom),
             1'($urandom), t[1] ? 5'(0) : 5'($urandom), t[1] ? 16'(0) : 16'($urandom));
    end

    // R8: idle with garbage on the inputs
    for (int n = 0; n < 20; n++)
      beat(0, 2'($urandom), {4'($urandom), 32'($urandom)}, rnd128(), 16'($urandom),
           16'($urandom), 0, '0, '0);

    // R9: set, hold, clear, then clear racing a new error
    beat(1, 2'b00, 36'h123456789, rnd128(), 16'hFFFF, 0, 0, 5'b10000, 0);
    beat(0, 0, 0, 0, 0, 0, 0, 0, 0);
    beat(1, 2'b01, 36'h0, rnd128(), 16'h0, 0, 1, 0, 0);
    beat(1, 2'b00, 36'hF00000000, 0, 0, 0, 0, 5'b00001, 16'h8000);
    beat(1, 2'b01, 0, rnd128(), 16'h00FF, 0, 1, 5'b11111, 16'h0001);
    beat(0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R1: top group covers only four bits
    beat(1, 2'b11, 36'hF_0000_0000, 0, 0, 0, 0, 0, 0);
    beat(1, 2'b11, 36'h7_0000_0000, 0, 0, 0, 0, 0, 0);
    // R7: poison every lane
    beat(1, 2'b10, 0, 0, 0, 16'hFFFF, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule